// File: doc/BRIEF.md
# Serial Shift-Register Output Driver

This block sends a parallel output word, such as a bank of PWM or GPIO levels, to an external serial-in parallel-out shift register chain. It uses three pins: serial data, a shift clock and a latch strobe. All timing comes from the system bus clock. Each bit occupies one shift-clock period, which is a programmable number of bus cycles (4, 8, 16 or 32). The rising shift-clock edge follows each data change by a programmable number of bus cycles, which gives the external register its setup time.

A single-cycle start pulse loads the word and launches a frame. The word goes out most-significant bit first. Two modes cover the two kinds of external register. In latch mode the frame ends with a one-period latch strobe, so the external part updates all of its outputs at once. In direct mode no strobe is produced, because the external outputs follow the bits as they shift in.

Configuration is written through a write strobe into pending settings. The settings are copied into the active frame settings only when a frame starts, so a running frame never changes its timing.

Top module: `serial_out_driver`

## Requirements
- R1: After reset, busy, sclk_o, sdata_o and latch_o are all low. The pending settings are: divisor code 3 (32 bus cycles per bit), delay 1, direct mode. These settings apply to a frame started without any configuration write.
- R2: A start pulse sampled while busy is low raises busy on the next cycle. A start pulse sampled while busy is high is ignored, and the running frame continues unchanged.
- R3: Bits leave MSB first. Each bit is presented on sdata_o for exactly one bit period, and the first bit appears in the cycle busy rises. While busy is low, and during the strobe period, sdata_o is low.
- R4: Divisor code cfg_div selects the bit period: 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32 bus cycles.
- R5: Let the effective delay be d and the half period be H = period/2. Within each bit period, counted from 0 at the data change, sclk_o is high for phases d through d+H-1 and low otherwise. sdata_o holds steady while sclk_o is high.
- R6: The effective delay is the written delay clamped to the range 1 to H. A written 0 becomes 1, and a value above H becomes H.
- R7: In latch mode (cfg_latch=1), latch_o is high for exactly one bit period right after the last bit period. sclk_o stays low during it, and busy falls in the cycle after it ends.
- R8: In direct mode latch_o never rises, and busy stays high for exactly FRAME_W bit periods.
- R9: A configuration write, including one made during a frame or in the same cycle as a start, affects only frames started after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the pending settings |
| cfg_div | input | 2 | Divisor code, period = 4 << code |
| cfg_dly | input | 5 | Requested data-to-clock delay in bus cycles |
| cfg_latch | input | 1 | 1 selects latch mode, 0 selects direct mode |
| start | input | 1 | Frame start pulse |
| word | input | FRAME_W | Word to send |
| busy | output | 1 | Frame in progress |
| sdata_o | output | 1 | Serial data to the external register |
| sclk_o | output | 1 | Shift clock to the external register |
| latch_o | output | 1 | Latch strobe to the external register |

## Verification
All outputs are decoded from registered state, so every result is due in the cycle that follows the clock edge on which its cause was sampled. Busy and the first data bit appear one cycle after start is accepted. A clock edge appears d cycles into its bit period, and the strobe starts FRAME_W·period cycles after the first bit. The bench model advances one step on each rising edge, using the same inputs the design samples. The bench then compares all four outputs against the model at the falling edge, half a cycle after each update, so every expected value is taken exactly in the cycle it is due.

// File: rtl/sod_pkg.sv
package sod_pkg;

  localparam int DIV_CODE_W = 2;
  localparam int DLY_W      = 5;
  localparam int PER_W      = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } sod_state_e;

  // bus cycles per bit period for a divisor code
  function automatic logic [PER_W-1:0] period_of(input logic [DIV_CODE_W-1:0] code);
    return PER_W'(6'd4 << code);
  endfunction

  // half of the bit period
  function automatic logic [DLY_W-1:0] half_of(input logic [DIV_CODE_W-1:0] code);
    logic [PER_W-1:0] p;
    p = period_of(code);
    return DLY_W'(p >> 1);
  endfunction

  // requested delay clamped into [1, period/2]
  function automatic logic [DLY_W-1:0] clamp_delay(input logic [DLY_W-1:0] req,
                                                   input logic [DIV_CODE_W-1:0] code);
    logic [DLY_W-1:0] h;
    h = half_of(code);
    if (req == '0)     return DLY_W'(1);
    else if (req > h)  return h;
    else               return req;
  endfunction

endpackage

// File: rtl/sod_cfg.sv
module sod_cfg
  import sod_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [DIV_CODE_W-1:0] wr_div,
  input  logic [DLY_W-1:0]      wr_dly,
  input  logic                  wr_latch,
  input  logic                  capture,
  output logic [PER_W-1:0]      act_period,
  output logic [DLY_W-1:0]      act_delay,
  output logic [DLY_W-1:0]      act_half,
  output logic                  act_latch
);

  localparam logic [DIV_CODE_W-1:0] RST_DIV = DIV_CODE_W'(3);
  localparam logic [DLY_W-1:0]      RST_DLY = DLY_W'(1);

  logic [DIV_CODE_W-1:0] pend_div;
  logic [DLY_W-1:0]      pend_dly;
  logic                  pend_latch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_div   <= RST_DIV;
      pend_dly   <= RST_DLY;
      pend_latch <= 1'b0;
    end else if (wr) begin
      pend_div   <= wr_div;
      pend_dly   <= wr_dly;
      pend_latch <= wr_latch;
    end
  end

  // active settings only move when a frame starts
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_period <= period_of(RST_DIV);
      act_delay  <= clamp_delay(RST_DLY, RST_DIV);
      act_half   <= half_of(RST_DIV);
      act_latch  <= 1'b0;
    end else if (capture) begin
      act_period <= period_of(pend_div);
      act_delay  <= clamp_delay(pend_dly, pend_div);
      act_half   <= half_of(pend_div);
      act_latch  <= pend_latch;
    end
  end

endmodule

// File: rtl/sod_timer.sv
module sod_timer
  import sod_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [PER_W-1:0] period,
  output logic [PER_W-1:0] phase,
  output logic             period_end
);

  assign period_end = run && (phase == period - PER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)          phase <= '0;
    else if (clear)      phase <= '0;
    else if (period_end) phase <= '0;
    else if (run)        phase <= phase + PER_W'(1);
  end

endmodule

// File: rtl/sod_shifter.sv
module sod_shifter #(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_word,
  input  logic               advance,
  output logic               msb,
  output logic               on_last
);

  localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   idx;

  assign msb     = sreg[FRAME_W-1];
  assign on_last = (idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg <= '0;
      idx  <= '0;
    end else if (load) begin
      sreg <= load_word;
      idx  <= '0;
    end else if (advance) begin
      sreg <= sreg << 1;
      idx  <= on_last ? idx : idx + CNT_W'(1);
    end
  end

endmodule

// File: rtl/serial_out_driver.sv
module serial_out_driver
  import sod_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_div,
  input  logic [4:0]         cfg_dly,
  input  logic               cfg_latch,
  input  logic               start,
  input  logic [FRAME_W-1:0] word,
  output logic               busy,
  output logic               sdata_o,
  output logic               sclk_o,
  output logic               latch_o
);

  sod_state_e       state, state_nx;
  logic             accept_w;
  logic             period_end_w;
  logic             bit_last_w;
  logic             shift_adv_w;
  logic             msb_w;
  logic [PER_W-1:0] phase;
  logic [PER_W-1:0] act_period;
  logic [DLY_W-1:0] act_delay;
  logic [DLY_W-1:0] act_half;
  logic             act_latch;
  logic [PER_W-1:0] rise_at;
  logic [PER_W-1:0] fall_at;

  assign accept_w    = start && (state == ST_IDLE);
  assign shift_adv_w = period_end_w && (state == ST_SHIFT);

  sod_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (cfg_we),
    .wr_div     (cfg_div),
    .wr_dly     (cfg_dly),
    .wr_latch   (cfg_latch),
    .capture    (accept_w),
    .act_period (act_period),
    .act_delay  (act_delay),
    .act_half   (act_half),
    .act_latch  (act_latch)
  );

  sod_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (accept_w),
    .run        (state != ST_IDLE),
    .period     (act_period),
    .phase      (phase),
    .period_end (period_end_w)
  );

  sod_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept_w),
    .load_word (word),
    .advance   (shift_adv_w),
    .msb       (msb_w),
    .on_last   (bit_last_w)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start) state_nx = ST_SHIFT;
      ST_SHIFT: if (period_end_w && bit_last_w)
                  state_nx = act_latch ? ST_LATCH : ST_IDLE;
      ST_LATCH: if (period_end_w) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  // clock-high window inside a bit period
  assign rise_at = PER_W'(act_delay);
  assign fall_at = PER_W'(act_delay) + PER_W'(act_half);

  assign busy    = (state != ST_IDLE);
  assign sdata_o = (state == ST_SHIFT) && msb_w;
  assign sclk_o  = (state == ST_SHIFT) && (phase >= rise_at) && (phase < fall_at);
  assign latch_o = (state == ST_LATCH);

endmodule

// File: rtl/sod_checker.sv
module sod_checker (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic sdata_o,
  input logic sclk_o,
  input logic latch_o,
  input logic act_latch,
  input logic period_end_w
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk_o && !latch_o && !sdata_o));

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  assert_latch_no_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(latch_o && sclk_o));

  assert_latch_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_o) |-> !busy);

  assert_latch_mode_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> act_latch);

  assert_busy_ends_on_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(period_end_w));

endmodule

bind serial_out_driver sod_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .sdata_o      (sdata_o),
  .sclk_o       (sclk_o),
  .latch_o      (latch_o),
  .act_latch    (act_latch),
  .period_end_w (period_end_w)
);

// File: tb/serial_out_driver_tb.sv
module serial_out_driver_tb;

  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_div = '0;
  logic [4:0] cfg_dly = '0;
  logic cfg_latch = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] word = '0;
  logic busy, sdata_o, sclk_o, latch_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  serial_out_driver #(.FRAME_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div),
    .cfg_dly(cfg_dly), .cfg_latch(cfg_latch), .start(start), .word(word),
    .busy(busy), .sdata_o(sdata_o), .sclk_o(sclk_o), .latch_o(latch_o)
  );

  // behavioural reference: time since frame start drives everything
  int p_per = 32, p_dly = 1, p_lat = 0;
  int a_per = 32, a_dly = 1, a_lat = 0;
  int m_busy = 0, m_t = 0;
  logic [W-1:0] m_word = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_per = 32; p_dly = 1; p_lat = 0;
      m_busy = 0; m_t = 0;
    end else begin
      if (m_busy != 0) begin
        m_t = m_t + 1;
        if (m_t == W * a_per + (a_lat != 0 ? a_per : 0)) m_busy = 0;
      end else if (start) begin
        a_per = p_per; a_lat = p_lat;
        a_dly = (p_dly < 1) ? 1 : p_dly;
        if (a_dly > p_per / 2) a_dly = p_per / 2;
        m_word = word; m_t = 0; m_busy = 1;
      end
      if (cfg_we) begin
        p_per = 4 * (1 << cfg_div); p_dly = int'(cfg_dly); p_lat = int'(cfg_latch);
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", tag, cycles, act, exp);
    end
  endtask

  // compare every cycle, half a clock after the update
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      logic e_d, e_c, e_l;
      int bitn, ph;
      e_d = 0; e_c = 0; e_l = 0;
      if (m_busy != 0) begin
        bitn = m_t / a_per; ph = m_t % a_per;
        if (bitn < W) begin
          e_d = m_word[W-1-bitn];
          e_c = (ph >= a_dly) && (ph < a_dly + a_per / 2);
        end else e_l = 1;
      end
      check("R2 R8 busy", busy, m_busy != 0);
      check("R3 sdata", sdata_o, e_d);
      check("R4 R5 R6 sclk", sclk_o, e_c);
      check("R7 R8 latch", latch_o, e_l);
    end
  end

  task automatic write_cfg(input logic [1:0] d, input logic [4:0] y, input logic l);
    @(negedge clk);
    cfg_we = 1; cfg_div = d; cfg_dly = y; cfg_latch = l;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // R2: busy due the cycle after an accepted start
  task automatic send(input logic [W-1:0] w);
    start = 1; word = w;
    @(negedge clk);
    start = 0;
    check("R2 busy after start", busy, 1'b1);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", busy, 1'b0);
    check("R1 sdata", sdata_o, 1'b0);
    check("R1 sclk", sclk_o, 1'b0);
    check("R1 latch", latch_o, 1'b0);
    rst_n = 1;
    @(negedge clk);
    // R1: default settings (32, delay 1, direct)
    send(8'hA5);
    repeat (40) @(negedge clk);
    // R2: start while busy ignored
    start = 1; word = 8'h0F;
    @(negedge clk);
    start = 0;
    // R9: write during frame applies only later; R6 clamp 20 -> 2
    write_cfg(2'd0, 5'd20, 1'b1);
    wait_idle();
    send(8'h3C);
    wait_idle();
    // R6: delay 0 -> 1, R7 latch mode with period 8
    write_cfg(2'd1, 5'd0, 1'b1);
    send(8'h81);
    wait_idle();
    // R8 direct mode, period 16, delay 8 (= half)
    write_cfg(2'd2, 5'd8, 1'b0);
    send(8'hFF);
    wait_idle();
    send(8'h00);
    wait_idle();
    // R9: write in same cycle as start goes to the next frame
    start = 1; word = 8'h96; cfg_we = 1; cfg_div = 2'd3; cfg_dly = 5'd16; cfg_latch = 1;
    @(negedge clk);
    start = 0; cfg_we = 0;
    check("R2 busy after start", busy, 1'b1);
    wait_idle();
    send(8'h5A);
    wait_idle();
    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule